// File: doc/BRIEF.md
# Reed-Solomon Symbol Correction Applier

This block takes the result of a Reed-Solomon decoder that works on 12-bit symbols and applies it to a page buffer holding 2048 data bytes followed by the spare bytes. A 12-bit symbol does not line up with bytes, so most corrections touch two neighbouring bytes. The block turns each symbol position into byte addresses and masks, then XORs each mask into the buffer with a read followed by a write on a byte-wide single-port buffer interface. When the job finishes it reports either how many symbols it corrected or that the page cannot be corrected.

A job arrives on a valid/ready handshake. It carries the decoder status word, an error count and up to four (position, pattern) pairs. `job_ready_o` is high only while the block is idle. A job is taken, and all of its inputs are sampled, on a clock edge where valid and ready are both high. Once taken, ready stays low until the job's done pulse has gone by, so a waiting source has to hold its job. A small front end also splits the four 32-bit syndrome words into eight 12-bit syndromes for the decoder.

The buffer is one flat byte space. Address 0 to 2047 is data byte 0 to 2047, and address 2048+k is spare byte k. The read data arrives one cycle after the read strobe.

Top module: `ecc_sym_fixer`

## Requirements
- R1: `syn_o[12k +: 12]` equals bits [11:0] of syndrome word k/2 when k is even, and bits [27:16] of that word when k is odd. Word j is `syn_words_i[32j +: 32]`.
- R2: `job_ready_o` is high only in the idle state. A job is sampled on the edge where `job_valid_i` and `job_ready_o` are both high. While a job is running, changes on the job inputs have no effect on the buffer or on the result.
- R3: If bit 18 of `ecc_status_i` is clear, the job makes no buffer access at all, and it completes with corrected count 0 and the uncorrectable flag clear.
- R4: For an odd position p with p ≤ 1374, with b = floor(3p/2): byte b is XORed with pattern>>4, and byte b+1 is XORed with (pattern<<4) truncated to 8 bits.
- R5: For an even position p with 2 ≤ p ≤ 1374, with b = floor(3p/2): byte b-1 is XORed with pattern>>8, and byte b is XORed with pattern[7:0].
- R6: Position 0 holds only 8 data bits. If pattern ≤ 0xFF, byte 0 is XORed with the pattern. Otherwise that error is not applied and the job is marked uncorrectable.
- R7: Position 1365 straddles the data/spare boundary: it updates data byte 2047 and spare byte 0. Positions 1366 to 1374 update only spare bytes, at spare index floor(3p/2)-2048 and its neighbour as R4/R5 give.
- R8: A position above 1374 is not applied and marks the job uncorrectable.
- R9: Errors are handled in list order, and each byte in turn is read and then written. A failing error does not stop the other errors in the list from being applied. Two errors that touch the same byte both take effect.
- R10: An error count above 4 (with bit 18 set) makes the job uncorrectable, and the buffer is not touched.
- R11: `done_o` is a one-cycle pulse at the end of each job. In that cycle the outputs show either corrected = count with the uncorrectable flag clear, or corrected = 0 with the flag set. Both values hold until the next done pulse.
- R12: Read and write strobes are never high in the same cycle. Every write goes to the address read in the cycle just before it, and the job makes as many reads as writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_valid_i | input | 1 | Job offered |
| job_ready_o | output | 1 | Block idle and able to take a job |
| ecc_status_i | input | 32 | Decoder status word; bit 18 enables correction |
| err_count_i | input | 3 | Number of listed errors |
| err_pos_i | input | 44 | Four 11-bit symbol positions, entry k at [11k +: 11] |
| err_pat_i | input | 48 | Four 12-bit error patterns, entry k at [12k +: 12] |
| syn_words_i | input | 128 | Four packed syndrome words |
| syn_o | output | 96 | Eight unpacked 12-bit syndromes |
| buf_addr_o | output | 12 | Buffer byte address |
| buf_rd_en_o | output | 1 | Buffer read strobe |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle job completion pulse |
| uncorrectable_o | output | 1 | Last job could not be fully corrected |
| corrected_o | output | 3 | Symbols corrected by the last job |

## Verification
The assertions check the buffer port protocol on every cycle: reads and writes never overlap, each read is followed by a write to the same address, and addresses stay inside the buffer. They also check that ready drops once a job is taken, that done lasts one cycle, that a failed job never reports a count, and that a job with bit 18 clear finishes at once without reading. Only the bench's scenarios can show that the right bytes received the right masks. That covers the odd and even split, position 0, the boundary symbol, the spare-area positions, overlapping errors and mixed good and bad lists, all checked against a byte-exact image of the buffer.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  // Symbol and byte geometry of the correction code
  localparam int SYM_W    = 12;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = SYM_W - BYTE_W;
  // Status bit that enables correction
  localparam int GATE_BIT = 18;
  // Bit offsets of the two syndromes packed into one 32-bit word
  localparam int SYN_LO_OFS = 0;
  localparam int SYN_HI_OFS = 16;
  localparam int WORD_W     = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD,
    ST_WR,
    ST_DONE
  } fix_state_e;
endpackage

// File: rtl/ecc_syn_unpack.sv
module ecc_syn_unpack
  import ecc_fix_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic [WORDS*WORD_W-1:0]  words_i,
  output logic [2*WORDS*SYM_W-1:0] syn_o
);
  logic [WORDS*WORD_W-1:0] words_unused_mask;
  logic                    unused_bits;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign syn_o[(2*w)*SYM_W   +: SYM_W] = words_i[w*WORD_W + SYN_LO_OFS +: SYM_W];
    assign syn_o[(2*w+1)*SYM_W +: SYM_W] = words_i[w*WORD_W + SYN_HI_OFS +: SYM_W];
    assign words_unused_mask[w*WORD_W +: WORD_W] =
      words_i[w*WORD_W +: WORD_W] & 32'hF000_F000;
  end

  assign unused_bits = ^words_unused_mask;
endmodule

// File: rtl/ecc_sym_map.sv
module ecc_sym_map
  import ecc_fix_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int MAX_POS = 1374,
  localparam int ADDR_W = POS_W + 1
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic              ok_o,
  output logic              two_o,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [BYTE_W-1:0] mask_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [BYTE_W-1:0] mask_b_o
);
  logic [POS_W+1:0] triple;
  logic [ADDR_W-1:0] half;

  // floor(3p/2) from shift-and-add
  assign triple = {2'b00, pos_i} + {1'b0, pos_i, 1'b0};
  assign half   = triple[POS_W+1:1];

  always_comb begin
    ok_o     = 1'b1;
    two_o    = 1'b1;
    addr_a_o = half;
    mask_a_o = '0;
    addr_b_o = half;
    mask_b_o = '0;
    if (pos_i > POS_W'(MAX_POS)) begin
      ok_o  = 1'b0;
      two_o = 1'b0;
    end else if (pos_i == '0) begin
      ok_o     = (pat_i[SYM_W-1:BYTE_W] == '0);
      two_o    = 1'b0;
      addr_a_o = '0;
      mask_a_o = pat_i[BYTE_W-1:0];
    end else if (pos_i[0]) begin
      addr_a_o = half;
      mask_a_o = pat_i[SYM_W-1:NIB_W];
      addr_b_o = half + ADDR_W'(1);
      mask_b_o = {pat_i[NIB_W-1:0], {NIB_W{1'b0}}};
    end else begin
      addr_a_o = half - ADDR_W'(1);
      mask_a_o = {{(BYTE_W-NIB_W){1'b0}}, pat_i[SYM_W-1:BYTE_W]};
      addr_b_o = half;
      mask_b_o = pat_i[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/ecc_sym_fixer.sv
module ecc_sym_fixer
  import ecc_fix_pkg::*;
#(
  parameter int MAX_ERR   = 4,
  parameter int POS_W     = 11,
  parameter int MAX_POS   = 1374,
  parameter int SYN_WORDS = 4,
  localparam int CNT_W    = $clog2(MAX_ERR + 1),
  localparam int IDX_W    = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1,
  localparam int ADDR_W   = POS_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         job_valid_i,
  output logic                         job_ready_o,
  input  logic [WORD_W-1:0]            ecc_status_i,
  input  logic [CNT_W-1:0]             err_count_i,
  input  logic [MAX_ERR*POS_W-1:0]     err_pos_i,
  input  logic [MAX_ERR*SYM_W-1:0]     err_pat_i,
  input  logic [SYN_WORDS*WORD_W-1:0]  syn_words_i,
  output logic [2*SYN_WORDS*SYM_W-1:0] syn_o,
  output logic [ADDR_W-1:0]            buf_addr_o,
  output logic                         buf_rd_en_o,
  input  logic [BYTE_W-1:0]            buf_rdata_i,
  output logic                         buf_wr_en_o,
  output logic [BYTE_W-1:0]            buf_wdata_o,
  output logic                         done_o,
  output logic                         uncorrectable_o,
  output logic [CNT_W-1:0]             corrected_o
);
  fix_state_e          state;
  logic [CNT_W-1:0]    idx_q, count_q, corr_q;
  logic                fail_q, unc_q, pend_q;
  logic [POS_W-1:0]    pos_q [MAX_ERR];
  logic [SYM_W-1:0]    pat_q [MAX_ERR];
  logic [ADDR_W-1:0]   cur_addr_q, pend_addr_q;
  logic [BYTE_W-1:0]   cur_mask_q, pend_mask_q;
  logic [IDX_W-1:0]    sel_idx;
  logic                map_ok, map_two;
  logic [ADDR_W-1:0]   map_addr_a, map_addr_b;
  logic [BYTE_W-1:0]   map_mask_a, map_mask_b;
  logic                gate;
  logic                unused_status;

  assign gate          = ecc_status_i[GATE_BIT];
  assign unused_status = ^{ecc_status_i[WORD_W-1:GATE_BIT+1], ecc_status_i[GATE_BIT-1:0]};

  ecc_syn_unpack #(.WORDS(SYN_WORDS)) u_unpack (
    .words_i (syn_words_i),
    .syn_o   (syn_o)
  );

  assign sel_idx = (idx_q < CNT_W'(MAX_ERR)) ? idx_q[IDX_W-1:0] : '0;

  ecc_sym_map #(.POS_W(POS_W), .MAX_POS(MAX_POS)) u_map (
    .pos_i    (pos_q[sel_idx]),
    .pat_i    (pat_q[sel_idx]),
    .ok_o     (map_ok),
    .two_o    (map_two),
    .addr_a_o (map_addr_a),
    .mask_a_o (map_mask_a),
    .addr_b_o (map_addr_b),
    .mask_b_o (map_mask_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx_q       <= '0;
      count_q     <= '0;
      corr_q      <= '0;
      fail_q      <= 1'b0;
      unc_q       <= 1'b0;
      pend_q      <= 1'b0;
      cur_addr_q  <= '0;
      cur_mask_q  <= '0;
      pend_addr_q <= '0;
      pend_mask_q <= '0;
      for (int k = 0; k < MAX_ERR; k++) begin
        pos_q[k] <= '0;
        pat_q[k] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          if (job_valid_i) begin
            idx_q   <= '0;
            fail_q  <= 1'b0;
            pend_q  <= 1'b0;
            count_q <= err_count_i;
            for (int k = 0; k < MAX_ERR; k++) begin
              pos_q[k] <= err_pos_i[k*POS_W +: POS_W];
              pat_q[k] <= err_pat_i[k*SYM_W +: SYM_W];
            end
            if (!gate) begin
              unc_q  <= 1'b0;
              corr_q <= '0;
              state  <= ST_DONE;
            end else if (err_count_i > CNT_W'(MAX_ERR)) begin
              unc_q  <= 1'b1;
              corr_q <= '0;
              state  <= ST_DONE;
            end else begin
              state <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          if (idx_q == count_q) begin
            unc_q  <= fail_q;
            corr_q <= fail_q ? '0 : count_q;
            state  <= ST_DONE;
          end else if (!map_ok) begin
            fail_q <= 1'b1;
            idx_q  <= idx_q + CNT_W'(1);
          end else begin
            cur_addr_q  <= map_addr_a;
            cur_mask_q  <= map_mask_a;
            pend_q      <= map_two;
            pend_addr_q <= map_addr_b;
            pend_mask_q <= map_mask_b;
            state       <= ST_RD;
          end
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (pend_q) begin
            cur_addr_q <= pend_addr_q;
            cur_mask_q <= pend_mask_q;
            pend_q     <= 1'b0;
            state      <= ST_RD;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
            state <= ST_EVAL;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign job_ready_o     = (state == ST_IDLE);
  assign buf_rd_en_o     = (state == ST_RD);
  assign buf_wr_en_o     = (state == ST_WR);
  assign buf_addr_o      = cur_addr_q;
  assign buf_wdata_o     = buf_rdata_i ^ cur_mask_q;
  assign done_o          = (state == ST_DONE);
  assign uncorrectable_o = unc_q;
  assign corrected_o     = corr_q;
endmodule

// File: rtl/ecc_sym_fixer_chk.sv
module ecc_sym_fixer_chk #(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 3,
  parameter int LAST_ADDR = 2061
) (
  input logic              clk,
  input logic              rst_n,
  input logic              job_valid,
  input logic              job_ready,
  input logic              gate,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic              done,
  input logic              unc,
  input logic [CNT_W-1:0]  corr
);
  p_no_rd_wr_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_wr_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en) && addr == $past(addr)));

  p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> wr_en);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready) |=> !job_ready);

  p_gated_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready && !gate) |=> (done && !rd_en && !wr_en));

  p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fail_no_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unc) |-> (corr == '0));

  p_addr_in_buffer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |-> (addr <= ADDR_W'(LAST_ADDR)));
endmodule

bind ecc_sym_fixer ecc_sym_fixer_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .LAST_ADDR ((3 * MAX_POS) / 2)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .job_valid (job_valid_i),
  .job_ready (job_ready_o),
  .gate      (ecc_status_i[ecc_fix_pkg::GATE_BIT]),
  .addr      (buf_addr_o),
  .rd_en     (buf_rd_en_o),
  .wr_en     (buf_wr_en_o),
  .done      (done_o),
  .unc       (uncorrectable_o),
  .corr      (corrected_o)
);

// File: tb/ecc_sym_fixer_bench.sv
module ecc_sym_fixer_bench;
  localparam int BUF_N = 2062;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         job_valid;
  logic         job_ready;
  logic [31:0]  ecc_status;
  logic [2:0]   err_count;
  logic [43:0]  err_pos;
  logic [47:0]  err_pat;
  logic [127:0] syn_words;
  logic [95:0]  syn;
  logic [11:0]  buf_addr;
  logic         buf_rd_en;
  logic [7:0]   buf_rdata;
  logic         buf_wr_en;
  logic [7:0]   buf_wdata;
  logic         done;
  logic         unc;
  logic [2:0]   corr;

  ecc_sym_fixer u_ecc_sym_fixer (
    .clk (clk), .rst_n (rst_n),
    .job_valid_i (job_valid), .job_ready_o (job_ready),
    .ecc_status_i (ecc_status), .err_count_i (err_count),
    .err_pos_i (err_pos), .err_pat_i (err_pat),
    .syn_words_i (syn_words), .syn_o (syn),
    .buf_addr_o (buf_addr), .buf_rd_en_o (buf_rd_en), .buf_rdata_i (buf_rdata),
    .buf_wr_en_o (buf_wr_en), .buf_wdata_o (buf_wdata),
    .done_o (done), .uncorrectable_o (unc), .corrected_o (corr)
  );

  int n_run = 0;
  int n_fail = 0;

  // Buffer model: one-cycle read latency, single port
  logic [7:0] mem     [BUF_N];
  logic [7:0] exp_mem [BUF_N];
  logic       load_req = 1'b0;
  logic [7:0] salt = 8'h00;
  int         wr_cnt = 0;
  int         rd_cnt = 0;

  function automatic logic [7:0] seed(int i, logic [7:0] s);
    return 8'((i * 37) ^ (i >> 3)) + s;
  endfunction

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < BUF_N; i++) mem[i] <= seed(i, salt);
    end else begin
      if (buf_rd_en) buf_rdata <= (int'(buf_addr) < BUF_N) ? mem[buf_addr] : 8'h00;
      if (buf_wr_en && int'(buf_addr) < BUF_N) mem[buf_addr] <= buf_wdata;
    end
    if (buf_wr_en) wr_cnt <= wr_cnt + 1;
    if (buf_rd_en) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic load_buf(logic [7:0] s);
    @(negedge clk);
    salt = s;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    for (int i = 0; i < BUF_N; i++) exp_mem[i] = seed(i, s);
  endtask

  task automatic check_mem(string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < BUF_N; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s buffer byte %0d actual=0x%0h expected=0x%0h (%0d bad)",
               req, first, mem[first], exp_mem[first], bad);
    end
  endtask

  // Reference: data byte d is at buffer index d, spare byte s at 2048+s
  task automatic xor_data(int d, int v);
    exp_mem[d] = exp_mem[d] ^ 8'(v);
  endtask
  task automatic xor_spare(int s, int v);
    exp_mem[2048 + s] = exp_mem[2048 + s] ^ 8'(v);
  endtask

  task automatic model_err(int p, int t, inout bit bad);
    int b;
    b = (3 * p) / 2;
    if (p > 1374) bad = 1'b1;
    else if (p == 0) begin
      if (t > 255) bad = 1'b1;
      else xor_data(0, t);
    end else if (p == 1365) begin
      xor_data(2047, t >> 4);
      xor_spare(0, (t << 4) & 255);
    end else if (p > 1365) begin
      if (p % 2 == 1) begin
        xor_spare(b - 2048, t >> 4);
        xor_spare(b - 2047, (t << 4) & 255);
      end else begin
        xor_spare(b - 2049, t >> 8);
        xor_spare(b - 2048, t & 255);
      end
    end else if (p % 2 == 1) begin
      xor_data(b, t >> 4);
      xor_data(b + 1, (t << 4) & 255);
    end else begin
      xor_data(b - 1, t >> 8);
      xor_data(b, t & 255);
    end
  endtask

  int  jp [4];
  int  jt [4];
  bit  r_unc;
  int  r_corr;
  int  r_wr;
  int  r_rd;
  bit  r_busy_ready;
  bit  r_done_after;
  bit  r_ok;
  bit  r_exp_bad;

  task automatic set_errs(int p0, int t0, int p1, int t1, int p2, int t2, int p3, int t3);
    jp[0] = p0; jt[0] = t0; jp[1] = p1; jt[1] = t1;
    jp[2] = p2; jt[2] = t2; jp[3] = p3; jt[3] = t3;
  endtask

  // Offers one job, waits for done; hold_busy keeps valid high with other data
  task automatic run_job(bit gate, int cnt, bit hold_busy);
    int w0;
    int r0;
    int n;
    @(negedge clk);
    ecc_status = gate ? 32'h0004_1234 : 32'hFFFB_FFFF;
    err_count  = 3'(cnt);
    for (int k = 0; k < 4; k++) begin
      err_pos[k*11 +: 11] = 11'(jp[k]);
      err_pat[k*12 +: 12] = 12'(jt[k]);
    end
    job_valid = 1'b1;
    w0 = wr_cnt;
    r0 = rd_cnt;
    @(negedge clk);
    r_busy_ready = job_ready;
    if (hold_busy) begin
      err_pos    = {4{11'd10}};
      err_pat    = {4{12'hFFF}};
      err_count  = 3'd4;
    end else begin
      job_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    r_ok   = done;
    r_unc  = unc;
    r_corr = int'(corr);
    job_valid = 1'b0;
    @(negedge clk);
    r_done_after = done;
    r_wr = wr_cnt - w0;
    r_rd = rd_cnt - r0;
    r_exp_bad = 1'b0;
    if (gate && cnt <= 4)
      for (int k = 0; k < cnt; k++) model_err(jp[k], jt[k], r_exp_bad);
  endtask

  task automatic t_reset;
    check("R2 ready after reset", int'(job_ready), 1);
    check("R11 done after reset", int'(done), 0);
    check("R12 no access after reset", int'(buf_rd_en | buf_wr_en), 0);
    check("R11 status after reset", int'({unc, corr}), 0);
  endtask

  task automatic t_unpack;
    logic [31:0] w [4];
    w[0] = 32'hA123_B456; w[1] = 32'h0FED_FCBA; w[2] = 32'h5000_9001; w[3] = 32'hF7F7_1E1E;
    syn_words = {w[3], w[2], w[1], w[0]};
    #1;
    for (int k = 0; k < 8; k++)
      check("R1 syndrome field", int'(syn[k*12 +: 12]),
            int'((w[k/2] >> ((k % 2 == 1) ? 16 : 0)) & 32'hFFF));
  endtask

  task automatic t_gate;
    load_buf(8'h11);
    set_errs(5, 12'hABC, 4, 12'h9D3, 0, 0, 0, 0);
    run_job(1'b0, 2, 1'b0);
    check("R3 gated done", int'(r_ok), 1);
    check("R3 gated corrected", r_corr, 0);
    check("R3 gated flag", int'(r_unc), 0);
    check("R3 gated writes", r_wr + r_rd, 0);
    check_mem("R3 gated buffer");
  endtask

  task automatic t_odd_even;
    load_buf(8'h22);
    set_errs(5, 12'hABC, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b0);
    check("R4 odd corrected", r_corr, 1);
    check("R4 odd writes", r_wr, 2);
    check_mem("R4 odd buffer");
    check("R11 done pulse width", int'(r_done_after), 0);
    set_errs(4, 12'h9D3, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b0);
    check("R5 even corrected", r_corr, 1);
    check("R12 reads equal writes", r_rd, r_wr);
    check_mem("R5 even buffer");
  endtask

  task automatic t_zero;
    load_buf(8'h33);
    set_errs(0, 12'h05A, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b0);
    check("R6 zero ok corrected", r_corr, 1);
    check("R6 zero ok writes", r_wr, 1);
    check_mem("R6 zero ok buffer");
    set_errs(0, 12'h15A, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b0);
    check("R6 zero wide flag", int'(r_unc), 1);
    check("R6 zero wide corrected", r_corr, 0);
    check("R6 zero wide writes", r_wr, 0);
    check_mem("R6 zero wide buffer");
  endtask

  task automatic t_boundary;
    load_buf(8'h44);
    set_errs(1365, 12'hF0F, 1367, 12'h3C5, 1374, 12'h7E1, 1366, 12'h248);
    run_job(1'b1, 4, 1'b0);
    check("R7 boundary corrected", r_corr, 4);
    check("R7 boundary flag", int'(r_unc), 0);
    check("R7 boundary writes", r_wr, 8);
    check_mem("R7 boundary and spare buffer");
  endtask

  task automatic t_range;
    load_buf(8'h55);
    set_errs(1375, 12'h001, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b0);
    check("R8 range flag", int'(r_unc), 1);
    check("R8 range writes", r_wr, 0);
    check_mem("R8 range buffer");
  endtask

  task automatic t_mixed;
    load_buf(8'h66);
    set_errs(1, 12'h123, 2, 12'h456, 2000, 12'hFFF, 700, 12'hA5A);
    run_job(1'b1, 4, 1'b0);
    check("R9 mixed flag", int'(r_unc), 1);
    check("R9 mixed corrected", r_corr, 0);
    check("R9 mixed writes", r_wr, 6);
    check_mem("R9 mixed and overlap buffer");
  endtask

  task automatic t_count;
    load_buf(8'h77);
    set_errs(5, 12'h111, 7, 12'h222, 9, 12'h333, 11, 12'h444);
    run_job(1'b1, 5, 1'b0);
    check("R10 overcount flag", int'(r_unc), 1);
    check("R10 overcount accesses", r_wr + r_rd, 0);
    check_mem("R10 overcount buffer");
    run_job(1'b1, 0, 1'b0);
    check("R11 empty list status", int'({r_unc, 3'(r_corr)}), 0);
    check("R11 empty list done", int'(r_ok), 1);
  endtask

  task automatic t_busy;
    load_buf(8'h88);
    set_errs(100, 12'h5A5, 0, 0, 0, 0, 0, 0);
    run_job(1'b1, 1, 1'b1);
    check("R2 ready low while busy", int'(r_busy_ready), 0);
    check("R2 busy corrected", r_corr, 1);
    check("R2 busy writes", r_wr, 2);
    check_mem("R2 busy inputs ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    job_valid  = 1'b0;
    ecc_status = '0;
    err_count  = '0;
    err_pos    = '0;
    err_pat    = '0;
    syn_words  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unpack();
    t_gate();
    t_odd_even();
    t_zero();
    t_boundary();
    t_range();
    t_mixed();
    t_count();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule